// File: doc/BRIEF.md
# Load-Exclusive Register-Pair Unit

This unit carries out a paired exclusive load. It accepts one decoded operation at a time. The operation holds an element-size bit, two destination register indices and a base register index. The unit picks the base address from the register-file read port, or from the stack-pointer value when the base index is 31. It then makes one or two 8-byte reads on a valid/ready memory request channel. The returned data is split into two 64-bit register writebacks, which appear together with a one-cycle completion pulse.

Narrow elements (32 bits) use one atomic 8-byte read. The two halves are routed to the destinations according to the endianness of the operation, and each half is zero-extended. Wide elements (64 bits) need a 16-byte aligned address and use two reads, at the base and at the base plus 8. Any operation that completes normally arms a local exclusive monitor with the block-aligned address. The monitor is dropped by a clear-exclusive pulse or by a store-exclusive probe.

The case where both destinations are the same register is resolved by a two-bit policy input. The policy can write a fixed fill value, raise an undefined-instruction fault, or retire the operation as a no-op. The latency depends only on the operation and on the memory handshakes, never on the loaded values.

Top module: `ldx_pair_unit`

## Requirements
- R1: `rf_idx` always equals `op_base`. The base address is `sp_value` when `op_base` is 31 and `rf_data` otherwise. `mem_req_tag_chk` is 1 exactly when the base index is not 31.
- R2: When the base index is 31 and `sp_value[3:0]` is not zero, the operation ends with `done` and `fault_sp_align`. It issues no memory request, writes no register and leaves the monitor unchanged.
- R3: A narrow operation (`op_wide`=0) issues exactly one 8-byte request at the base address. With `big_endian`=0, bits 31:0 of the response go to `wb1` and bits 63:32 go to `wb2`. With `big_endian`=1 these are swapped. Both values are zero-extended to 64 bits.
- R4: A wide operation whose base has `addr[3:0]` not zero ends with `done` and `fault_align`. It issues no request, writes no register and leaves the monitor unchanged.
- R5: An aligned wide operation issues two requests, first at the base and then at the base plus 8. The first response goes to `wb1` and the second to `wb2`.
- R6: Every operation that does not fault and is not a no-op sets `mon_valid`. It sets `mon_addr` to the base with its low 3 bits cleared (narrow) or its low 4 bits cleared (wide).
- R7: A cycle with `clrex` or `excl_check` high, and no operation accepted, clears `mon_valid`.
- R8: With `op_dst1`==`op_dst2` and `overlap_mode`=0, the unit issues no request. It writes `UNKNOWN_FILL` to `wb1` only (`wb2_en`=0) and arms the monitor.
- R9: With `op_dst1`==`op_dst2` and `overlap_mode`=1, the operation ends with `fault_undef`. It issues no request, writes no register and leaves the monitor unchanged.
- R10: With `op_dst1`==`op_dst2` and `overlap_mode` of 2 or 3, the operation ends with `done` and no fault. It issues no request, writes no register and leaves the monitor unchanged.
- R11: `done` is high for single cycles only. `op_ready` is low from acceptance until completion, so it is low while a request is outstanding.
- R12: `mem_req_big_endian` carries the operation's `big_endian` value. `mem_req_bytes` is 8. A stalled request keeps its address stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when valid |
| op_wide | input | 1 | 1 selects 64-bit elements, 0 selects 32-bit elements |
| op_dst1 | input | 5 | First destination index |
| op_dst2 | input | 5 | Second destination index |
| op_base | input | 5 | Base register index, 31 selects the stack pointer |
| big_endian | input | 1 | Endianness of the access |
| overlap_mode | input | 2 | Equal-destination policy: 0 fill, 1 undefined, 2 or 3 no-op |
| rf_idx | output | 5 | Register-file read index |
| rf_data | input | 64 | Register-file read data |
| sp_value | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address |
| mem_req_bytes | output | 4 | Read size in bytes, always 8 |
| mem_req_big_endian | output | 1 | Endianness flag of the read |
| mem_req_tag_chk | output | 1 | Tag checking enabled for the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Completion pulse |
| wb1_en | output | 1 | First writeback enable |
| wb1_idx | output | 5 | First writeback index |
| wb1_data | output | 64 | First writeback value |
| wb2_en | output | 1 | Second writeback enable |
| wb2_idx | output | 5 | Second writeback index |
| wb2_data | output | 64 | Second writeback value |
| fault_sp_align | output | 1 | Stack-pointer alignment fault |
| fault_align | output | 1 | Wide-pair alignment fault |
| fault_undef | output | 1 | Undefined-instruction fault |
| clrex | input | 1 | Clear-exclusive pulse |
| excl_check | input | 1 | Store-exclusive probe, consumes the mark |
| mon_valid | output | 1 | Exclusive monitor armed |
| mon_addr | output | 64 | Aligned address held by the monitor |

## Verification
The hardest situations to reach are the cases where the monitor must stay unchanged: faults and no-ops that arrive while a mark from an earlier load is still held. The stimulus therefore arms the monitor with a load to a known block before each faulting or equal-destination operation, and then compares the monitor address afterwards. A wide load is also run against a responder that grants requests only on alternate cycles. This keeps a request stalled, and the address must hold while the second beat's address is still formed correctly.

// File: rtl/ldx_pair_unit.sv
module ldx_pair_unit #(
  parameter logic [63:0] UNKNOWN_FILL = 64'hBAD0_F00D_BAD0_F00D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  output logic        op_ready,
  input  logic        op_wide,
  input  logic [4:0]  op_dst1,
  input  logic [4:0]  op_dst2,
  input  logic [4:0]  op_base,
  input  logic        big_endian,
  input  logic [1:0]  overlap_mode,
  output logic [4:0]  rf_idx,
  input  logic [63:0] rf_data,
  input  logic [63:0] sp_value,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  output logic [3:0]  mem_req_bytes,
  output logic        mem_req_big_endian,
  output logic        mem_req_tag_chk,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic        wb1_en,
  output logic [4:0]  wb1_idx,
  output logic [63:0] wb1_data,
  output logic        wb2_en,
  output logic [4:0]  wb2_idx,
  output logic [63:0] wb2_data,
  output logic        fault_sp_align,
  output logic        fault_align,
  output logic        fault_undef,
  input  logic        clrex,
  input  logic        excl_check,
  output logic        mon_valid,
  output logic [63:0] mon_addr
);
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam logic [4:0] SP_IDX = 5'd31;

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT} state_t;
  state_t state;

  logic            beat, wide_q, be_q, tag_q;
  logic [4:0]      dst1_q, dst2_q;
  logic [XLEN-1:0] base_q, first_q;

  logic [XLEN-1:0] base_addr;
  logic            accept, sp_bad, same_dst, misaligned;

  assign rf_idx     = op_base;
  assign base_addr  = (op_base == SP_IDX) ? sp_value : rf_data;
  assign accept     = op_valid && op_ready;
  assign sp_bad     = (op_base == SP_IDX) && (sp_value[3:0] != 4'd0);
  assign same_dst   = (op_dst1 == op_dst2);
  assign misaligned = op_wide && (base_addr[3:0] != 4'd0);

  assign op_ready           = (state == IDLE);
  assign mem_req_valid      = (state == ISSUE);
  assign mem_req_addr       = base_q + (beat ? XLEN'(8) : XLEN'(0));
  assign mem_req_bytes      = 4'd8;
  assign mem_req_big_endian = be_q;
  assign mem_req_tag_chk    = tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      beat <= 1'b0;
      wide_q <= 1'b0;
      be_q <= 1'b0;
      tag_q <= 1'b0;
      dst1_q <= '0;
      dst2_q <= '0;
      base_q <= '0;
      first_q <= '0;
      done <= 1'b0;
      wb1_en <= 1'b0;
      wb2_en <= 1'b0;
      wb1_idx <= '0;
      wb2_idx <= '0;
      wb1_data <= '0;
      wb2_data <= '0;
      fault_sp_align <= 1'b0;
      fault_align <= 1'b0;
      fault_undef <= 1'b0;
      mon_valid <= 1'b0;
      mon_addr <= '0;
    end else begin
      done <= 1'b0;
      wb1_en <= 1'b0;
      wb2_en <= 1'b0;
      fault_sp_align <= 1'b0;
      fault_align <= 1'b0;
      fault_undef <= 1'b0;
      if (clrex || excl_check) mon_valid <= 1'b0;

      unique case (state)
        IDLE: if (accept) begin
          wide_q <= op_wide;
          be_q   <= big_endian;
          tag_q  <= (op_base != SP_IDX);
          dst1_q <= op_dst1;
          dst2_q <= op_dst2;
          base_q <= base_addr;
          beat   <= 1'b0;
          if (sp_bad) begin
            done <= 1'b1;
            fault_sp_align <= 1'b1;
          end else if (same_dst && overlap_mode == 2'd1) begin
            done <= 1'b1;
            fault_undef <= 1'b1;
          end else if (same_dst && overlap_mode[1]) begin
            done <= 1'b1;
          end else if (same_dst) begin
            done <= 1'b1;
            wb1_en <= 1'b1;
            wb1_idx <= op_dst1;
            wb1_data <= UNKNOWN_FILL;
            mon_valid <= 1'b1;
            mon_addr <= op_wide ? {base_addr[XLEN-1:4], 4'd0} : {base_addr[XLEN-1:3], 3'd0};
          end else if (misaligned) begin
            done <= 1'b1;
            fault_align <= 1'b1;
          end else begin
            mon_valid <= 1'b1;
            mon_addr <= op_wide ? {base_addr[XLEN-1:4], 4'd0} : {base_addr[XLEN-1:3], 3'd0};
            state <= ISSUE;
          end
        end
        ISSUE: if (mem_req_ready) state <= WAIT;
        WAIT: if (mem_rsp_valid) begin
          if (wide_q && !beat) begin
            first_q <= mem_rsp_data;
            beat <= 1'b1;
            state <= ISSUE;
          end else begin
            state <= IDLE;
            done <= 1'b1;
            wb1_en <= 1'b1;
            wb2_en <= 1'b1;
            wb1_idx <= dst1_q;
            wb2_idx <= dst2_q;
            if (wide_q) begin
              wb1_data <= first_q;
              wb2_data <= mem_rsp_data;
            end else if (be_q) begin
              wb1_data <= {{HALF{1'b0}}, mem_rsp_data[XLEN-1:HALF]};
              wb2_data <= {{HALF{1'b0}}, mem_rsp_data[HALF-1:0]};
            end else begin
              wb1_data <= {{HALF{1'b0}}, mem_rsp_data[HALF-1:0]};
              wb2_data <= {{HALF{1'b0}}, mem_rsp_data[XLEN-1:HALF]};
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

module ldx_pair_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        op_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        done,
  input logic        wb1_en,
  input logic        wb2_en,
  input logic        fault_sp_align,
  input logic        fault_align,
  input logic        fault_undef,
  input logic        clrex,
  input logic        excl_check,
  input logic        mon_valid,
  input logic [63:0] mon_addr
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !op_ready);
  a_r2_sp_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    fault_sp_align |-> (done && !wb1_en && !wb2_en));
  a_r4_align_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    fault_align |-> (done && !wb1_en && !wb2_en));
  a_r9_undef_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    fault_undef |-> (done && !wb1_en && !wb2_en));
  a_r7_clear_drops_mark: assert property (@(posedge clk) disable iff (!rst_n)
    ((clrex || excl_check) && !(op_valid && op_ready)) |=> !mon_valid);
  a_r12_stall_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r6_mark_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mon_valid |-> (mon_addr[2:0] == 3'd0));
endmodule

bind ldx_pair_unit ldx_pair_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .wb1_en(wb1_en), .wb2_en(wb2_en),
  .fault_sp_align(fault_sp_align), .fault_align(fault_align),
  .fault_undef(fault_undef), .clrex(clrex), .excl_check(excl_check),
  .mon_valid(mon_valid), .mon_addr(mon_addr)
);

// File: tb/ldx_pair_unit_tb_top.sv
module ldx_pair_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] FILL = 64'hBAD0_F00D_BAD0_F00D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_wide = 1'b0, big_endian = 1'b0;
  logic [4:0] op_dst1 = 5'd1, op_dst2 = 5'd2, op_base = 5'd5;
  logic [1:0] overlap_mode = 2'd0;
  logic [4:0] rf_idx;
  logic [63:0] rf_data = '0, sp_value = '0;
  logic mem_req_valid, mem_req_big_endian, mem_req_tag_chk;
  logic [63:0] mem_req_addr;
  logic [3:0] mem_req_bytes;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic done, wb1_en, wb2_en, fault_sp_align, fault_align, fault_undef, mon_valid;
  logic [4:0] wb1_idx, wb2_idx;
  logic [63:0] wb1_data, wb2_data, mon_addr;
  logic clrex = 1'b0, excl_check = 1'b0;
  logic stall_mode = 1'b0;
  logic cyc_par = 1'b0;
  logic mem_req_ready;

  int checks = 0, failures = 0;
  int req_cnt = 0;
  logic [63:0] log_addr [4];
  logic log_be [4];
  logic log_tag [4];
  logic [3:0] log_bytes [4];
  logic exp_mv = 1'b0;
  logic [63:0] exp_ma = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_req_ready = stall_mode ? cyc_par : 1'b1;

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_0F0F, a[31:0] + 32'h1357_9BDF};
  endfunction

  always @(posedge clk) begin
    cyc_par <= ~cyc_par;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data <= mem_word(mem_req_addr);
      log_addr[req_cnt % 4] <= mem_req_addr;
      log_be[req_cnt % 4] <= mem_req_big_endian;
      log_tag[req_cnt % 4] <= mem_req_tag_chk;
      log_bytes[req_cnt % 4] <= mem_req_bytes;
      req_cnt <= req_cnt + 1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  ldx_pair_unit #(.UNKNOWN_FILL(FILL)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_wide(op_wide), .op_dst1(op_dst1), .op_dst2(op_dst2), .op_base(op_base),
    .big_endian(big_endian), .overlap_mode(overlap_mode), .rf_idx(rf_idx),
    .rf_data(rf_data), .sp_value(sp_value), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_bytes(mem_req_bytes), .mem_req_big_endian(mem_req_big_endian),
    .mem_req_tag_chk(mem_req_tag_chk), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .wb1_en(wb1_en), .wb1_idx(wb1_idx),
    .wb1_data(wb1_data), .wb2_en(wb2_en), .wb2_idx(wb2_idx), .wb2_data(wb2_data),
    .fault_sp_align(fault_sp_align), .fault_align(fault_align),
    .fault_undef(fault_undef), .clrex(clrex), .excl_check(excl_check),
    .mon_valid(mon_valid), .mon_addr(mon_addr)
  );
  logic op_ready;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic wide, input logic be, input logic [4:0] base_idx,
                        input logic [4:0] d1, input logic [4:0] d2,
                        input logic [63:0] gpr, input logic [63:0] spv, input logic [1:0] mode);
    logic [63:0] base, w, e1, e2;
    int start, n;
    bit sp_f, undef_f, nop_f, unk_f, al_f, load_f;
    base = (base_idx == 5'd31) ? spv : gpr;
    sp_f = (base_idx == 5'd31) && (spv[3:0] != 0);
    undef_f = !sp_f && d1 == d2 && mode == 2'd1;
    nop_f = !sp_f && d1 == d2 && mode >= 2'd2;
    unk_f = !sp_f && d1 == d2 && mode == 2'd0;
    al_f = !sp_f && d1 != d2 && wide && base[3:0] != 0;
    load_f = !sp_f && d1 != d2 && !al_f;
    @(negedge clk);
    op_wide = wide; big_endian = be; op_base = base_idx; op_dst1 = d1; op_dst2 = d2;
    rf_data = gpr; sp_value = spv; overlap_mode = mode; op_valid = 1'b1;
    start = req_cnt;
    #1;
    check(rf_idx == base_idx, "R1 rf_idx", 64'(rf_idx), 64'(base_idx));
    @(negedge clk);
    op_valid = 1'b0;
    n = 0;
    while (!done && n < 60) begin
      check(!op_ready, "R11 ready low while busy", 64'(op_ready), 64'd0);
      @(negedge clk);
      n++;
    end
    check(done, "R11 done seen", 64'(done), 64'd1);
    check(fault_sp_align == sp_f, "R2 sp fault flag", 64'(fault_sp_align), 64'(sp_f));
    check(fault_align == al_f, "R4 align fault flag", 64'(fault_align), 64'(al_f));
    check(fault_undef == undef_f, "R9 undef fault flag", 64'(fault_undef), 64'(undef_f));
    check(wb1_en == (unk_f || load_f), "R10 wb1 enable", 64'(wb1_en), 64'(unk_f || load_f));
    check(wb2_en == load_f, "R8 wb2 enable", 64'(wb2_en), 64'(load_f));
    if (unk_f) begin
      check(wb1_data == FILL && wb1_idx == d1, "R8 fill value", wb1_data, FILL);
      check(req_cnt == start, "R8 no request", 64'(req_cnt - start), 64'd0);
    end
    if (sp_f || undef_f || nop_f || al_f)
      check(req_cnt == start, "R10 no request on fault or no-op", 64'(req_cnt - start), 64'd0);
    if (load_f && !wide) begin
      w = mem_word(base);
      e1 = be ? {32'd0, w[63:32]} : {32'd0, w[31:0]};
      e2 = be ? {32'd0, w[31:0]} : {32'd0, w[63:32]};
      check(req_cnt == start + 1, "R3 one request", 64'(req_cnt - start), 64'd1);
      check(log_addr[start % 4] == base, "R1 R3 request address", log_addr[start % 4], base);
      check(wb1_data == e1 && wb1_idx == d1, "R3 first half", wb1_data, e1);
      check(wb2_data == e2 && wb2_idx == d2, "R3 second half", wb2_data, e2);
    end
    if (load_f && wide) begin
      check(req_cnt == start + 2, "R5 two requests", 64'(req_cnt - start), 64'd2);
      check(log_addr[start % 4] == base, "R5 first address", log_addr[start % 4], base);
      check(log_addr[(start + 1) % 4] == base + 64'd8, "R5 second address",
            log_addr[(start + 1) % 4], base + 64'd8);
      check(wb1_data == mem_word(base) && wb1_idx == d1, "R5 first dword", wb1_data, mem_word(base));
      check(wb2_data == mem_word(base + 64'd8) && wb2_idx == d2, "R5 second dword",
            wb2_data, mem_word(base + 64'd8));
    end
    if (load_f) begin
      check(log_be[start % 4] == be, "R12 endian flag", 64'(log_be[start % 4]), 64'(be));
      check(log_bytes[start % 4] == 4'd8, "R12 size", 64'(log_bytes[start % 4]), 64'd8);
      check(log_tag[start % 4] == (base_idx != 5'd31), "R1 tag check", 64'(log_tag[start % 4]),
            64'(base_idx != 5'd31));
    end
    if (load_f || unk_f) begin
      exp_mv = 1'b1;
      exp_ma = wide ? {base[63:4], 4'd0} : {base[63:3], 3'd0};
    end
    check(mon_valid == exp_mv, "R6 monitor valid", 64'(mon_valid), 64'(exp_mv));
    check(mon_addr == exp_ma || !exp_mv, "R6 monitor address", mon_addr, exp_ma);
    @(negedge clk);
    check(!done, "R11 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic pulse_clear(input bit use_check, input string req);
    @(negedge clk);
    if (use_check) excl_check = 1'b1; else clrex = 1'b1;
    @(negedge clk);
    excl_check = 1'b0; clrex = 1'b0;
    exp_mv = 1'b0;
    check(!mon_valid, req, 64'(mon_valid), 64'd0);
  endtask

  initial begin
    logic [63:0] g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(op_ready && !done && !mon_valid && !mem_req_valid, "R11 reset state",
          {60'd0, op_ready, done, mon_valid, mem_req_valid}, 64'h8);
    for (int wide = 0; wide < 2; wide++)
      for (int be = 0; be < 2; be++)
        for (int off = 0; off < 8; off++) begin
          g = 64'h0000_1234_5678_0100 + 64'(off * 4);
          run_op(wide[0], be[0], 5'd5, 5'd1, 5'd2, g, 64'h0, 2'd0);
        end
    run_op(1'b1, 1'b0, 5'd31, 5'd3, 5'd4, 64'h7777_0000, 64'h0000_0000_00AB_CD40, 2'd0);
    run_op(1'b0, 1'b1, 5'd31, 5'd3, 5'd4, 64'h7777_0000, 64'h0000_0000_00AB_CD80, 2'd0);
    run_op(1'b1, 1'b0, 5'd31, 5'd3, 5'd4, 64'h7777_0000, 64'h0000_0000_00AB_CD48, 2'd0);
    run_op(1'b0, 1'b0, 5'd31, 5'd3, 5'd4, 64'h7777_0000, 64'h0000_0000_00AB_CD44, 2'd0);
    run_op(1'b1, 1'b0, 5'd6, 5'd7, 5'd8, 64'h0000_9000, 64'h0, 2'd0);
    for (int m = 1; m < 4; m++)
      run_op(1'b1, 1'b0, 5'd6, 5'd9, 5'd9, 64'h0000_A000, 64'h0, m[1:0]);
    run_op(1'b0, 1'b0, 5'd6, 5'd9, 5'd9, 64'h0000_B004, 64'h0, 2'd0);
    run_op(1'b1, 1'b1, 5'd6, 5'd9, 5'd9, 64'h0000_C008, 64'h0, 2'd0);
    pulse_clear(1'b0, "R7 clrex clears mark");
    run_op(1'b0, 1'b0, 5'd6, 5'd10, 5'd11, 64'h0000_D00C, 64'h0, 2'd0);
    pulse_clear(1'b1, "R7 store-exclusive probe clears mark");
    run_op(1'b1, 1'b0, 5'd6, 5'd10, 5'd11, 64'h0000_E004, 64'h0, 2'd0);
    stall_mode = 1'b1;
    run_op(1'b1, 1'b1, 5'd12, 5'd13, 5'd14, 64'h0000_F010, 64'h0, 2'd0);
    run_op(1'b0, 1'b1, 5'd12, 5'd13, 5'd14, 64'h0000_F018, 64'h0, 2'd0);
    stall_mode = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule